// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This unit settles conditional branches while the branch sits in the decode stage of a five-stage in-order pipeline. It looks at the instruction held in the fetch/decode pipeline register, the sequential address that fetch stored beside it, and the register value the register file read for the branch's source field. From these it produces three results. The first is a taken flag. The second is the branch destination, formed by a private adder. The third is a request to clear the fetch/decode register. Because these are known in decode, a taken branch wastes only the one instruction fetched behind it. Waiting for the memory stage would waste three.

Two branch kinds are recognised: jump when the tested register is zero, and jump when it is not zero. Every other opcode passes through untouched. The taken flag and destination are combinational and feed the program-counter select multiplexer in the same cycle. The clear request is also combinational and acts on the pipeline register at the next clock edge.

A mode pin selects delay-slot behaviour. In that mode the instruction after a branch always executes, so no clear is requested. A one-bit state register remembers that a clear was just issued. This stops the cleared slot from being resolved as a branch in the following cycle, even if the pipeline register only drops its valid bit.

Top module: `brid_resolve`

## Requirements
- R1: The destination `br_target` equals `ifid_npc` plus the 16-bit offset in `ifid_instr[15:0]`, sign-extended by copying bit 15 into all upper bits. The sum wraps modulo 2^32. It is driven this way in every cycle.
- R2: Opcode field `ifid_instr[31:26]` = 6'h04 is jump-if-zero. Its test register is the one named by `ifid_instr[25:21]`, whose value arrives on `rs_value`. It is taken exactly when `rs_value` is zero.
- R3: Opcode 6'h05 is jump-if-nonzero. It tests the same field and is taken exactly when `rs_value` is not zero.
- R4: When `ifid_valid` is low, or the opcode is neither 6'h04 nor 6'h05, `br_taken` and `ifid_flush` stay low whatever `rs_value` holds.
- R5: With `slot_mode` low, `ifid_flush` equals `br_taken` in the same cycle. A branch that is not taken requests no clear.
- R6: With `slot_mode` high, `ifid_flush` is never asserted. Taken branches still raise `br_taken`, and the next instruction resolves normally.
- R7: In the cycle right after `ifid_flush` was high, the decode-stage instruction is treated as cleared. `br_taken` and `ifid_flush` are low, so a clear lasts exactly one cycle.
- R8: The synchronous active-high `rst` clears the remembered-clear state. A branch in the first cycle after reset resolves normally, even if a clear was requested during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_mode | input | 1 | 1 = delay-slot behaviour, no clear requests |
| ifid_valid | input | 1 | Fetch/decode register holds a live instruction |
| ifid_instr | input | 32 | Instruction word in decode |
| ifid_npc | input | 32 | Sequential address (branch address + 4) |
| rs_value | input | 32 | Register file value for the source field |
| br_taken | output | 1 | Branch resolved taken this cycle |
| br_target | output | 32 | Branch destination address |
| ifid_flush | output | 1 | Clear the fetch/decode register at the next edge |

## Verification
Every cycle, the assertions check four things:
- non-branches and invalid slots never take or clear;
- a taken jump-if-zero only ever saw a zero register, and the nonzero kind only a nonzero one;
- a clear always matches a taken branch outside delay-slot mode and never occurs inside it;
- a clear is never followed by a taken branch.

Only the bench's scenarios can show the rest:
- the exact destination arithmetic, including negative offsets and address wrap;
- that a branch sitting directly behind a clear is dropped while the one after it resolves;
- that reset forgets a pending clear.

// File: rtl/brid_pkg.sv
package brid_pkg;
    localparam int unsigned ILEN   = 32;
    localparam int unsigned OPC_W  = 6;
    localparam int unsigned OPC_LO = ILEN - OPC_W;
    localparam int unsigned OFS_W  = 16;

    localparam logic [OPC_W-1:0] OPC_JZ  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_JNZ = 6'h05;

    typedef enum logic [1:0] {
        BK_NONE    = 2'd0,
        BK_ZERO    = 2'd1,
        BK_NONZERO = 2'd2
    } br_kind_e;

    typedef struct packed {
        br_kind_e             kind;
        logic [OFS_W-1:0]     ofs;
    } br_fields_t;

    function automatic br_kind_e kind_of(input logic [OPC_W-1:0] opc);
        case (opc)
            OPC_JZ:  return BK_ZERO;
            OPC_JNZ: return BK_NONZERO;
            default: return BK_NONE;
        endcase
    endfunction
endpackage

// File: rtl/brid_decode.sv
module brid_decode
    import brid_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             squash,
    input  logic [ILEN-1:0]  instr,
    output br_fields_t       fields
);
    logic [OPC_W-1:0] opc;

    always_comb begin
        opc         = instr[ILEN-1:OPC_LO];
        fields.ofs  = instr[OFS_W-1:0];
        fields.kind = (valid && !squash) ? kind_of(opc) : BK_NONE;
    end

    // R4: a recognised kind only for the two branch opcodes
    a_r4_kind_from_opcode: assert property (@(posedge clk) disable iff (rst)
        (fields.kind != BK_NONE) |-> (valid && (opc == OPC_JZ || opc == OPC_JNZ)));
endmodule

// File: rtl/brid_zero_test.sv
module brid_zero_test
    import brid_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  br_kind_e         kind,
    input  logic [XLEN-1:0]  value,
    output logic             take
);
    logic is_zero;

    always_comb begin
        is_zero = ~|value;
        case (kind)
            BK_ZERO:    take = is_zero;
            BK_NONZERO: take = ~is_zero;
            default:    take = 1'b0;
        endcase
    end
endmodule

// File: rtl/brid_target_add.sv
module brid_target_add #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned OFS_W = 16
) (
    input  logic [XLEN-1:0]  npc,
    input  logic [OFS_W-1:0] ofs,
    output logic [XLEN-1:0]  target
);
    localparam int unsigned EXT_W = XLEN - OFS_W;

    logic [XLEN-1:0] ofs_ext;

    always_comb begin
        ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
        target  = npc + ofs_ext;
    end
endmodule

// File: rtl/brid_resolve.sv
module brid_resolve
    import brid_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_mode,
    input  logic             ifid_valid,
    input  logic [ILEN-1:0]  ifid_instr,
    input  logic [XLEN-1:0]  ifid_npc,
    input  logic [XLEN-1:0]  rs_value,
    output logic             br_taken,
    output logic [XLEN-1:0]  br_target,
    output logic             ifid_flush
);
    br_fields_t fields;
    logic       squash_q;
    logic       take;

    brid_decode u_decode (
        .clk    (clk),
        .rst    (rst),
        .valid  (ifid_valid),
        .squash (squash_q),
        .instr  (ifid_instr),
        .fields (fields)
    );

    brid_zero_test #(.XLEN(XLEN)) u_zero (
        .kind  (fields.kind),
        .value (rs_value),
        .take  (take)
    );

    brid_target_add #(.XLEN(XLEN), .OFS_W(OFS_W)) u_add (
        .npc    (ifid_npc),
        .ofs    (fields.ofs),
        .target (br_target)
    );

    always_comb begin
        br_taken   = take;
        ifid_flush = take && !slot_mode;
    end

    // R7/R8: remembers that the slot now in decode was cleared
    always_ff @(posedge clk) begin
        if (rst) squash_q <= 1'b0;
        else     squash_q <= ifid_flush;
    end

    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!ifid_valid || (ifid_instr[ILEN-1:OPC_LO] != OPC_JZ &&
                         ifid_instr[ILEN-1:OPC_LO] != OPC_JNZ)) |-> (!br_taken && !ifid_flush));

    a_r2_zero_only: assert property (@(posedge clk) disable iff (rst)
        (br_taken && ifid_instr[ILEN-1:OPC_LO] == OPC_JZ) |-> (rs_value == '0));

    a_r3_nonzero_only: assert property (@(posedge clk) disable iff (rst)
        (br_taken && ifid_instr[ILEN-1:OPC_LO] == OPC_JNZ) |-> (rs_value != '0));

    a_r5_flush_tracks_taken: assert property (@(posedge clk) disable iff (rst)
        !slot_mode |-> (ifid_flush == br_taken));

    a_r6_slot_no_flush: assert property (@(posedge clk) disable iff (rst)
        slot_mode |-> !ifid_flush);

    a_r7_cleared_slot_idle: assert property (@(posedge clk) disable iff (rst)
        ifid_flush |=> (!br_taken && !ifid_flush));
endmodule

// File: tb/test_brid_resolve.sv
module test_brid_resolve;
    localparam int unsigned CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        slot_mode;
    logic        ifid_valid;
    logic [31:0] ifid_instr;
    logic [31:0] ifid_npc;
    logic [31:0] rs_value;
    logic        br_taken;
    logic [31:0] br_target;
    logic        ifid_flush;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    bit model_sq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brid_resolve i_brid_resolve (
        .clk        (clk),
        .rst        (rst),
        .slot_mode  (slot_mode),
        .ifid_valid (ifid_valid),
        .ifid_instr (ifid_instr),
        .ifid_npc   (ifid_npc),
        .rs_value   (rs_value),
        .br_taken   (br_taken),
        .br_target  (br_target),
        .ifid_flush (ifid_flush)
    );

    function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] rs,
                                       input logic [15:0] ofs);
        return {opc, rs, 5'd0, ofs};
    endfunction

    task automatic step(input logic r, input logic v, input logic m, input logic [31:0] ins,
                        input logic [31:0] npc, input logic [31:0] rv, input string tag);
        logic        e_taken;
        logic        e_flush;
        logic [31:0] e_tgt;
        logic [5:0]  opc;
        bit          isbr;
        @(negedge clk);
        rst = r; ifid_valid = v; slot_mode = m; ifid_instr = ins; ifid_npc = npc; rs_value = rv;
        #1;
        opc     = ins[31:26];
        isbr    = v && !model_sq && (opc == 6'h04 || opc == 6'h05);
        e_taken = isbr && ((opc == 6'h04) ? (rv == 0) : (rv != 0));
        e_flush = e_taken && !m;
        e_tgt   = npc + 32'(signed'(ins[15:0]));
        checks++;
        if (br_taken !== e_taken || ifid_flush !== e_flush || br_target !== e_tgt) begin
            errors++;
            $display("FAIL %s: taken=%b flush=%b target=%h expected taken=%b flush=%b target=%h",
                     tag, br_taken, ifid_flush, br_target, e_taken, e_flush, e_tgt);
        end
        @(posedge clk);
        model_sq = r ? 1'b0 : e_flush;
    endtask

    initial begin
        rst = 1'b1; slot_mode = 1'b0; ifid_valid = 1'b0;
        ifid_instr = '0; ifid_npc = '0; rs_value = '0;
        step(1, 0, 0, 32'h0, 32'h0, 32'h0, "R8 reset idle");
        step(1, 0, 0, 32'h0, 32'h0, 32'h0, "R8 reset idle");
        // R2 jump-if-zero
        step(0, 1, 0, mk(6'h04, 5'd3, 16'h0010), 32'h0000_1004, 32'h0, "R2 zero taken");
        step(0, 1, 0, 32'h0, 32'h0000_1008, 32'h5, "R7 slot after clear");
        step(0, 1, 0, mk(6'h04, 5'd3, 16'h0010), 32'h0000_100C, 32'h1, "R2 nonzero not taken");
        // R3 jump-if-nonzero
        step(0, 1, 0, mk(6'h05, 5'd7, 16'h0020), 32'h0000_2004, 32'h8000_0000, "R3 nonzero taken");
        step(0, 1, 0, 32'h0, 32'h0, 32'h0, "R5 bubble");
        step(0, 1, 0, mk(6'h05, 5'd7, 16'h0020), 32'h0000_2004, 32'h0, "R3 zero not taken");
        // R1 offsets
        step(0, 1, 0, mk(6'h05, 5'd1, 16'h8000), 32'h0001_0000, 32'h0, "R1 most negative offset");
        step(0, 1, 0, mk(6'h05, 5'd1, 16'h7FFF), 32'h0001_0000, 32'h0, "R1 most positive offset");
        step(0, 1, 0, mk(6'h05, 5'd1, 16'h0008), 32'hFFFF_FFFC, 32'h0, "R1 wrap");
        step(0, 1, 0, mk(6'h00, 5'd1, 16'hFFFC), 32'h0000_0040, 32'h0, "R1 any opcode");
        // R4 non-branches and invalid
        step(0, 1, 0, mk(6'h00, 5'd0, 16'h0004), 32'h40, 32'h0, "R4 opcode 0");
        step(0, 1, 0, mk(6'h06, 5'd0, 16'h0004), 32'h40, 32'h0, "R4 opcode 6");
        step(0, 1, 0, mk(6'h24, 5'd0, 16'h0004), 32'h40, 32'h0, "R4 opcode 0x24");
        step(0, 0, 0, mk(6'h04, 5'd0, 16'h0004), 32'h40, 32'h0, "R4 invalid slot");
        // R7 branch directly behind a clear is dropped, next resolves
        step(0, 1, 0, mk(6'h04, 5'd2, 16'h0100), 32'h80, 32'h0, "R5 taken clears");
        step(0, 1, 0, mk(6'h04, 5'd2, 16'h0100), 32'h84, 32'h0, "R7 dropped branch");
        step(0, 1, 0, mk(6'h04, 5'd2, 16'h0100), 32'h88, 32'h0, "R7 resolves again");
        // R6 delay-slot mode
        step(0, 1, 1, mk(6'h04, 5'd2, 16'h0100), 32'h90, 32'h0, "R6 taken no clear");
        step(0, 1, 1, mk(6'h05, 5'd2, 16'hFFF0), 32'h94, 32'h3, "R6 slot branch resolves");
        step(0, 1, 1, mk(6'h05, 5'd2, 16'hFFF0), 32'h98, 32'h0, "R6 not taken");
        // R8 reset forgets a pending clear
        step(1, 1, 0, mk(6'h04, 5'd2, 16'h0004), 32'hA0, 32'h0, "R8 clear during reset");
        step(0, 1, 0, mk(6'h04, 5'd2, 16'h0004), 32'hA4, 32'h0, "R8 first branch after reset");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [5:0]  op;
            logic [31:0] rv;
            case ($urandom_range(0, 3))
                0: op = 6'h04;
                1: op = 6'h05;
                default: op = 6'($urandom);
            endcase
            rv = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
            step(0, ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) == 0),
                 mk(op, 5'($urandom), 16'($urandom)), $urandom, rv, "R2 R3 R5 mixed");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule